// File: doc/BRIEF.md
# DRAM Mode-Register Power-Up Sequencer

This block drives the mode-register programming that brings an LPDDR-class memory device out of power-on. After a start pulse it stays quiet for a power-up interval. It then issues six mode-register writes in a fixed order: the device reset register (MR63), ZQ initialisation (MR10), then MR3, MR1, MR2 and MR11. Each write places a command word on `cmd_word` and holds `cmd_strobe` high for a dwell time. The dwell after the reset command is the longer one.

The six register values and a rank-configuration word are captured when the start pulse is accepted. Rank 0 is always programmed. The whole six-write list is then repeated for rank 1 only when the dual-rank bit that belongs to this channel is set in the configuration word. All intervals are given in microseconds and turned into cycle counts from a clock-frequency parameter.

Top module: `mrs_init_seq`

## Requirements
- R1: While reset is held and after reset, `cmd_strobe`, `seq_done` and `busy` are 0 and `cmd_word` is 0.
- R2: An accepted start raises `busy` at once. `cmd_strobe` then stays low for exactly CLK_MHZ*PWRUP_US cycles before the first write.
- R3: Writes for each rank come in this order: MR63, MR10, MR3, MR1, MR2, MR11 (ports `mr63_val` ... `mr11_val`).
- R4: While `cmd_strobe` is high, `cmd_word` equals the rank number shifted to bit RANK_BIT (28), ORed with the register value, zero-extended to CMD_W bits. It is stable for the whole strobe.
- R5: The strobe stays high for exactly CLK_MHZ*RESET_DWELL_US cycles for the MR63 write and CLK_MHZ*MR_DWELL_US cycles for every other write. Between two consecutive writes it is low for exactly one cycle.
- R6: The dual-rank flag is bit (17 − CHAN_IDX) of `rank_cfg`, which is bit 17 for channel 0. When it is set, six more writes with rank 1 follow the rank-0 writes, for 12 in total. Otherwise only 6 writes are issued. Other bits of `rank_cfg` have no effect.
- R7: `seq_done` is high for exactly one cycle, the first cycle after the strobe of the final write falls. `busy` is low in the following cycle.
- R8: A start pulse while `busy` is high is ignored. The running sequence keeps its timing and write count.
- R9: Register values and `rank_cfg` are sampled when start is accepted. Later changes do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the power-up sequence (accepted when idle) |
| rank_cfg | input | CFG_W | Configuration word holding the per-channel dual-rank bits |
| mr63_val | input | VAL_W | Reset register command value |
| mr10_val | input | VAL_W | ZQ init register command value |
| mr3_val | input | VAL_W | MR3 command value |
| mr1_val | input | VAL_W | MR1 command value |
| mr2_val | input | VAL_W | MR2 command value |
| mr11_val | input | VAL_W | MR11 command value |
| cmd_word | output | CMD_W | Command word: rank at RANK_BIT ORed with value |
| cmd_strobe | output | 1 | Command strobe, high during each write's dwell |
| seq_done | output | 1 | One-cycle pulse when the sequence finishes |
| busy | output | 1 | Sequence in progress |

## Verification
The bench measures every strobe length. A design that uses the short dwell for the reset write, or is off by one in its counter, shows up as a wrong pulse length at the first or a later write. Runs are made with bit 16 alone and with both rank bits set. A design that decodes the wrong channel bit would issue 12 writes where 6 are expected, or the reverse. One run pulses start and rewrites all values and the rank word during the power-up wait. A design that restarts or samples live inputs would change its timing, its rank-1 pass or its command words. The gap between writes and the position of the done pulse are also checked, so an extra or missing idle cycle is caught.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

   localparam int SLOTS = 6;
   localparam int IDX_W = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWRUP,
      ST_PULSE,
      ST_GAP,
      ST_FINISH
   } seq_state_t;

   function automatic int us_to_cycles(input int mhz, input int us);
      return mhz * us;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/mrs_cfg_capture.sv
module mrs_cfg_capture #(
   parameter int VAL_W       = 28,
   parameter int SLOTS       = 6,
   parameter bit CAPTURE_CFG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [SLOTS*VAL_W-1:0] vals_in,
   input  logic                   dual_in,
   output logic [SLOTS*VAL_W-1:0] vals_out,
   output logic                   dual_out
);

   generate
      if (CAPTURE_CFG) begin : g_capture
         logic [SLOTS*VAL_W-1:0] vals_q;
         logic                   dual_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vals_q <= '0;
               dual_q <= 1'b0;
            end else if (load) begin
               vals_q <= vals_in;
               dual_q <= dual_in;
            end
         end
         assign vals_out = vals_q;
         assign dual_out = dual_q;
      end else begin : g_live
         assign vals_out = vals_in;
         assign dual_out = dual_in;
      end
   endgenerate

endmodule

// File: rtl/mrs_slot_mux.sv
module mrs_slot_mux #(
   parameter int VAL_W    = 28,
   parameter int CMD_W    = 32,
   parameter int RANK_BIT = 28,
   parameter int SLOTS    = 6,
   parameter int IDX_W    = 3
) (
   input  logic [SLOTS*VAL_W-1:0] vals,
   input  logic [IDX_W-1:0]       idx,
   input  logic                   rank,
   output logic [CMD_W-1:0]       word,
   output logic                   long_dwell
);

   logic [VAL_W-1:0] slot_val [SLOTS];

   genvar g;
   generate
      for (g = 0; g < SLOTS; g++) begin : g_unpack
         assign slot_val[g] = vals[g*VAL_W +: VAL_W];
      end
   endgenerate

   logic [VAL_W-1:0] sel_val;

   always_comb begin
      sel_val = '0;
      for (int k = 0; k < SLOTS; k++) begin
         if (idx == IDX_W'(k)) sel_val = slot_val[k];
      end
   end

   always_comb begin
      word = '0;
      word[VAL_W-1:0] = sel_val;
      word[RANK_BIT] = word[RANK_BIT] | rank;
   end

   // slot 0 is the device reset command, which needs the long dwell
   assign long_dwell = (idx == '0);

endmodule

// File: rtl/mrs_dwell_timer.sv
module mrs_dwell_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // a non-zero count must drain by exactly one per cycle (R5 timing basis)
   assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mrs_init_seq.sv
module mrs_init_seq #(
   parameter int CLK_MHZ        = 100,
   parameter int PWRUP_US       = 200,
   parameter int RESET_DWELL_US = 10,
   parameter int MR_DWELL_US    = 1,
   parameter int VAL_W          = 28,
   parameter int CMD_W          = 32,
   parameter int RANK_BIT       = 28,
   parameter int CFG_W          = 32,
   parameter int CHAN_IDX       = 0,
   parameter bit CAPTURE_CFG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CFG_W-1:0] rank_cfg,
   input  logic [VAL_W-1:0] mr63_val,
   input  logic [VAL_W-1:0] mr10_val,
   input  logic [VAL_W-1:0] mr3_val,
   input  logic [VAL_W-1:0] mr1_val,
   input  logic [VAL_W-1:0] mr2_val,
   input  logic [VAL_W-1:0] mr11_val,
   output logic [CMD_W-1:0] cmd_word,
   output logic             cmd_strobe,
   output logic             seq_done,
   output logic             busy
);
   import mrs_seq_pkg::*;

   localparam int N_PWR    = us_to_cycles(CLK_MHZ, PWRUP_US);
   localparam int N_RST    = us_to_cycles(CLK_MHZ, RESET_DWELL_US);
   localparam int N_STD    = us_to_cycles(CLK_MHZ, MR_DWELL_US);
   localparam int N_MAX    = max3(N_PWR, N_RST, N_STD);
   localparam int CNT_W    = $clog2(N_MAX + 1);
   localparam int DUAL_BIT = 17 - CHAN_IDX;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

   generate
      if (CHAN_IDX < 0 || CHAN_IDX > 1)
         $error("CHAN_IDX must be 0 or 1");
      if (DUAL_BIT >= CFG_W)
         $error("rank_cfg too narrow for the dual-rank bit");
      if (RANK_BIT < VAL_W || RANK_BIT >= CMD_W)
         $error("RANK_BIT must sit above the value and inside the command word");
      if (N_PWR < 1 || N_RST < 1 || N_STD < 1)
         $error("every interval must be at least one cycle");
   endgenerate

   seq_state_t        state;
   logic [IDX_W-1:0]  idx;
   logic              rank;
   logic              accept;
   logic              dual_rank;
   logic [SLOTS*VAL_W-1:0] vals_all;
   logic [SLOTS*VAL_W-1:0] vals_use;
   logic [CMD_W-1:0]  slot_word;
   logic              slot_long;
   logic              t_load;
   logic [CNT_W-1:0]  t_val;
   logic              t_exp;
   logic              last_write;

   assign accept   = (state == ST_IDLE) && start;
   assign vals_all = {mr11_val, mr2_val, mr1_val, mr3_val, mr10_val, mr63_val};

   mrs_cfg_capture #(
      .VAL_W       (VAL_W),
      .SLOTS       (SLOTS),
      .CAPTURE_CFG (CAPTURE_CFG)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .vals_in  (vals_all),
      .dual_in  (rank_cfg[DUAL_BIT]),
      .vals_out (vals_use),
      .dual_out (dual_rank)
   );

   mrs_slot_mux #(
      .VAL_W    (VAL_W),
      .CMD_W    (CMD_W),
      .RANK_BIT (RANK_BIT),
      .SLOTS    (SLOTS),
      .IDX_W    (IDX_W)
   ) u_mux (
      .vals       (vals_use),
      .idx        (idx),
      .rank       (rank),
      .word       (slot_word),
      .long_dwell (slot_long)
   );

   mrs_dwell_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   assign last_write = (idx == LAST_IDX) && (rank || !dual_rank);

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      case (state)
         ST_IDLE: begin
            t_load = accept;
            t_val  = CNT_W'(N_PWR - 1);
         end
         ST_PWRUP, ST_GAP: begin
            t_load = (state == ST_GAP) || t_exp;
            t_val  = slot_long ? CNT_W'(N_RST - 1) : CNT_W'(N_STD - 1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         idx      <= '0;
         rank     <= 1'b0;
         cmd_word <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_PWRUP;
                  idx   <= '0;
                  rank  <= 1'b0;
               end
            end
            ST_PWRUP: begin
               if (t_exp) begin
                  state    <= ST_PULSE;
                  cmd_word <= slot_word;
               end
            end
            ST_PULSE: begin
               if (t_exp) begin
                  if (last_write) begin
                     state <= ST_FINISH;
                  end else begin
                     state <= ST_GAP;
                     if (idx == LAST_IDX) begin
                        idx  <= '0;
                        rank <= 1'b1;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end
               end
            end
            ST_GAP: begin
               state    <= ST_PULSE;
               cmd_word <= slot_word;
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_strobe = (state == ST_PULSE);
   assign seq_done   = (state == ST_FINISH);
   assign busy       = (state != ST_IDLE);

   assert_pwrup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !cmd_strobe);

   assert_word_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strobe && $past(cmd_strobe)) |-> $stable(cmd_word));

   assert_rank1_needs_dual_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strobe && cmd_word[RANK_BIT]) |-> dual_rank);

   assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_done) |-> $past(cmd_strobe));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> (!seq_done && !busy));

   assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !seq_done && start) |=> busy);

endmodule

// File: tb/mrs_init_seq_test.sv
module mrs_init_seq_test;

   localparam int CLK_MHZ = 2;
   localparam int N_PWR   = CLK_MHZ * 200;
   localparam int N_RST   = CLK_MHZ * 10;
   localparam int N_STD   = CLK_MHZ * 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] rank_cfg = '0;
   logic [27:0] v63 = '0, v10 = '0, v3 = '0, v1 = '0, v2 = '0, v11 = '0;
   logic [31:0] cmd_word;
   logic        cmd_strobe, seq_done, busy;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mrs_init_seq #(.CLK_MHZ(CLK_MHZ)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rank_cfg(rank_cfg),
      .mr63_val(v63), .mr10_val(v10), .mr3_val(v3), .mr1_val(v1),
      .mr2_val(v2), .mr11_val(v11),
      .cmd_word(cmd_word), .cmd_strobe(cmd_strobe), .seq_done(seq_done), .busy(busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [27:0] slot_value(input logic [27:0] base, input int k);
      return base + 28'(k) * 28'h0010203;
   endfunction

   task automatic load_values(input logic [27:0] base);
      v63 = slot_value(base, 0);
      v10 = slot_value(base, 1);
      v3  = slot_value(base, 2);
      v1  = slot_value(base, 3);
      v2  = slot_value(base, 4);
      v11 = slot_value(base, 5);
   endtask

   // inject: pulse start and rewrite every input during the power-up wait
   task automatic run_seq(input logic [31:0] cfg, input logic [27:0] base,
                          input int n_exp, input bit inject);
      logic [31:0] words [12];
      int hi_len [12];
      int nw = 0, pre = 0, cur_hi = 0, cur_lo = 0, cyc = 0;
      bit seen_hi = 1'b0, got_done = 1'b0;
      @(negedge clk);
      rank_cfg = cfg;
      load_values(base);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", 32'(busy), 32'd1);
      while (!got_done && cyc < 5000) begin
         if (inject && cyc == 5) begin
            start = 1'b1;
            rank_cfg = 32'h0003_0000;
            load_values(base ^ 28'h0ABCDEF);
         end
         if (inject && cyc == 6) start = 1'b0;
         if (cmd_strobe) begin
            if (cur_hi == 0) begin
               if (nw < 12) words[nw] = cmd_word;
               if (seen_hi) check("R5 gap between writes", 32'(cur_lo), 32'd1);
            end
            cur_hi++;
            cur_lo = 0;
         end else begin
            if (cur_hi > 0) begin
               if (nw < 12) hi_len[nw] = cur_hi;
               nw++;
               cur_hi = 0;
               seen_hi = 1'b1;
            end
            if (!seen_hi) pre++;
            else cur_lo++;
            if (seq_done) begin
               got_done = 1'b1;
               check("R7 done right after last strobe", 32'(cur_lo), 32'd1);
            end
         end
         cyc++;
         if (!got_done) @(negedge clk);
      end
      check("R7 done observed", 32'(got_done), 32'd1);
      @(negedge clk);
      check("R7 done single cycle", 32'(seq_done), 32'd0);
      check("R7 busy low after done", 32'(busy), 32'd0);
      check("R2 power-up quiet cycles", 32'(pre), 32'(N_PWR));
      check("R6 write count", 32'(nw), 32'(n_exp));
      for (int k = 0; k < n_exp && k < nw && k < 12; k++) begin
         check("R3 R4 command word", words[k],
               ({31'd0, k >= 6} << 28) | {4'd0, slot_value(base, k % 6)});
         check("R5 strobe dwell", 32'(hi_len[k]), (k % 6 == 0) ? 32'(N_RST) : 32'(N_STD));
      end
   endtask

   typedef struct packed {
      logic [31:0] cfg;
      logic [27:0] base;
      logic [3:0]  n_exp;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{cfg: 32'h0000_0000, base: 28'h0000123, n_exp: 4'd6},
      '{cfg: 32'h0002_0000, base: 28'h0F00A50, n_exp: 4'd12},
      '{cfg: 32'h0001_0000, base: 28'h7654321, n_exp: 4'd6},
      '{cfg: 32'hFFFF_FFFF, base: 28'hFFFFFF0, n_exp: 4'd12}
   };

   initial begin
      #1;
      check("R1 strobe in reset", 32'(cmd_strobe), 32'd0);
      check("R1 done in reset", 32'(seq_done), 32'd0);
      check("R1 busy in reset", 32'(busy), 32'd0);
      check("R1 word in reset", cmd_word, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", 32'(busy), 32'd0);
      check("R1 word after reset", cmd_word, 32'd0);

      for (int i = 0; i < 4; i++)
         run_seq(VECS[i].cfg, VECS[i].base, int'(VECS[i].n_exp), 1'b0);

      // R8 R9: start and input changes mid-run must not disturb the sequence
      run_seq(32'h0000_0000, 28'h0135790, 6, 1'b1);

      // R8: idle stays idle without a start
      repeat (4) @(negedge clk);
      check("R8 stays idle", 32'(busy), 32'd0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(10 * 50000);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule